// File: doc/BRIEF.md
# Windowed Register File Controller

This block keeps a processor's general registers in a ring of register windows, each window a full set of architectural registers. A procedure call, or entry into a trap handler, moves the current window pointer forward onto a fresh window, and a return moves it back. The caller's or the interrupted code's registers therefore stay intact without any software save or restore. All register reads and writes are addressed relative to the window the pointer selects.

The controller counts how many windows hold live data. When a forward move would land on a window that is still live, the move does not happen and an overflow flag is raised instead. When a return would leave no live window, the move does not happen and an underflow flag is raised instead. A handler then asks the block to stream half of the windows out to memory (spill) or back in from memory (fill), one register per cycle over valid/ready handshakes. While a transfer runs the block reports busy, and pointer moves and register writes are dropped. Each flag stays raised until the handler acknowledges it.

Top module: `regwin_ctrl`

## Requirements
- R1: After a synchronous reset the pointer is 0, the live-window count is 1, both trap flags are low and busy is low.
- R2: A call or a trap entry (trap entry has exactly the same effect) with fewer than 8 live windows advances the pointer by one modulo 8 and raises the count by one. If call or trap entry is high together with return, the return is ignored.
- R3: A return with more than one live window moves the pointer back by one modulo 8 and lowers the count by one. The count never leaves the range 1 to 8.
- R4: A call or trap entry with 8 live windows sets the overflow flag and leaves pointer and count unchanged.
- R5: A return with one live window sets the underflow flag and leaves pointer and count unchanged.
- R6: A trap flag stays high until trap acknowledge is seen, which clears both flags. A new trap in the same cycle as the acknowledge leaves its flag set.
- R7: A write stores into register wr_idx of the current window. rd_data_o shows, one cycle after rd_idx_i is presented, that register of the window that was current then. A write is visible to a read presented in the next cycle. A read of the same register in the cycle of the write returns the old value.
- R8: A write made in the same cycle as a call or return lands in the window that was current before the move.
- R9: A spill request while idle with more than 4 live windows makes the block busy. It then sends 64 words, one per cycle while ready is high. The words come from the 4 oldest live windows, starting at window (pointer - count + 1) mod 8 and going upward, with registers 0 to 15 in ascending order within each window. The word is held while valid is high and ready is low. At the end the count drops by 4 and busy falls. A spill request with 4 or fewer live windows is ignored.
- R10: A fill request while idle with 4 or fewer live windows accepts 64 words in the same window and register order. The words go into the 4 windows just below the oldest live one, starting at window (pointer - count - 3) mod 8. At the end the count rises by 4. A fill request with more than 4 live windows is ignored. A spill request takes precedence over a fill request.
- R11: While busy, call, return, trap entry and writes have no effect. A call, return or trap entry in the cycle that starts a transfer is also dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call: move to a new window |
| ret_i | input | 1 | Return: move back to the previous window |
| trap_enter_i | input | 1 | Trap or mode-switch entry: move to a new window |
| trap_ack_i | input | 1 | Clears both trap flags |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 4 | Register index of the write within the current window |
| wr_data_i | input | 32 | Write data |
| rd_idx_i | input | 4 | Register index of the read within the current window |
| rd_data_o | output | 32 | Read data, one cycle after the index |
| cwp_o | output | 3 | Current window pointer |
| resident_o | output | 4 | Number of live windows, 1 to 8 |
| ovf_trap_o | output | 1 | Overflow trap pending |
| unf_trap_o | output | 1 | Underflow trap pending |
| busy_o | output | 1 | Spill or fill in progress |
| spill_req_i | input | 1 | Start a spill of the 4 oldest windows |
| fill_req_i | input | 1 | Start a fill of 4 windows below the oldest |
| spill_valid_o | output | 1 | Spill word valid |
| spill_ready_i | input | 1 | Memory side accepts the spill word |
| spill_data_o | output | 32 | Spill word |
| fill_valid_i | input | 1 | Fill word valid |
| fill_ready_o | output | 1 | Block accepts fill words |
| fill_data_i | input | 32 | Fill word |

## Verification
On every cycle the assertions check these properties: the count stays within 1 to 8; the pointer only ever moves by one step; pointer and count hold still when a trap flag rises; each flag persists until acknowledged; the pointer is frozen while a transfer runs; and an unaccepted spill word holds still. Only the bench's scenarios can show the rest. These are the register contents seen through the windows, including writes that race a call or return, the exact order and values of spilled words, where filled words land, and the drops during busy and at a transfer's start cycle. The bench shows these by tracking every window's contents and comparing reads and streamed words against that model.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_SPILL = 2'd1,
    XF_FILL  = 2'd2
  } xf_state_t;
endpackage

// File: rtl/regwin_mem.sv
// Window storage: one write port, one registered read port (read-first),
// shaped so that a block RAM is inferred.
module regwin_mem #(
  parameter int DW = 32,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    q <= ram[raddr];
  end
endmodule

// File: rtl/regwin_ptr.sv
// Window pointer, live-window count and trap flags.
module regwin_ptr #(
  parameter int NWIN = 8,
  parameter int HALF = NWIN / 2,
  localparam int WW = $clog2(NWIN),
  localparam int CW = $clog2(NWIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          call,
  input  logic          ret,
  input  logic          ack,
  input  logic          spill_done,
  input  logic          fill_done,
  output logic [WW-1:0] cwp,
  output logic [CW-1:0] resident,
  output logic          ovf,
  output logic          unf,
  output logic [WW-1:0] oldest
);
  // Oldest live window; with a full ring the low bits of the count are 0.
  assign oldest = WW'(cwp - resident[WW-1:0] + WW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp      <= '0;
      resident <= CW'(1);
      ovf      <= 1'b0;
      unf      <= 1'b0;
    end else begin
      if (ack) begin
        ovf <= 1'b0;
        unf <= 1'b0;
      end
      if (spill_done) begin
        resident <= resident - CW'(HALF);
      end else if (fill_done) begin
        resident <= resident + CW'(HALF);
      end else if (en) begin
        if (call) begin
          if (resident == CW'(NWIN)) begin
            ovf <= 1'b1;
          end else begin
            cwp      <= cwp + WW'(1);
            resident <= resident + CW'(1);
          end
        end else if (ret) begin
          if (resident == CW'(1)) begin
            unf <= 1'b1;
          end else begin
            cwp      <= cwp - WW'(1);
            resident <= resident - CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/regwin_xfer.sv
// Bulk spill/fill sequencer for half of the windows.
module regwin_xfer
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NREG = 16,
  parameter int HALF = NWIN / 2,
  localparam int WW    = $clog2(NWIN),
  localparam int RW    = $clog2(NREG),
  localparam int CW    = $clog2(NWIN + 1),
  localparam int AW    = WW + RW,
  localparam int BEATS = HALF * NREG,
  localparam int CNTW  = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spill_req,
  input  logic          fill_req,
  input  logic [CW-1:0] resident,
  input  logic [WW-1:0] oldest,
  input  logic          spill_ready,
  input  logic          fill_valid,
  output logic          busy,
  output logic          start,
  output logic          spill_valid,
  output logic          fill_ready,
  output logic          spill_done,
  output logic          fill_done,
  output logic [AW-1:0] raddr,
  output logic          we,
  output logic [AW-1:0] waddr
);
  xf_state_t       state;
  logic [CNTW-1:0] cnt;
  logic [WW-1:0]   base;
  logic            vld;
  logic            start_spill, start_fill, sp_fire, last;
  logic [CNTW-1:0] rcnt;

  function automatic logic [AW-1:0] beat_addr(input logic [WW-1:0] b,
                                              input logic [CNTW-1:0] c);
    logic [WW-1:0] w;
    w = WW'(b + WW'(c[CNTW-1:RW]));
    return {w, c[RW-1:0]};
  endfunction

  assign start_spill = (state == XF_IDLE) && spill_req && (resident > CW'(HALF));
  assign start_fill  = (state == XF_IDLE) && fill_req && !start_spill &&
                       (resident <= CW'(NWIN - HALF));
  assign start       = start_spill || start_fill;
  assign busy        = (state != XF_IDLE);
  assign spill_valid = vld;
  assign fill_ready  = (state == XF_FILL);
  assign last        = (cnt == CNTW'(BEATS - 1));
  assign sp_fire     = (state == XF_SPILL) && vld && spill_ready;
  assign spill_done  = sp_fire && last;
  assign we          = fill_ready && fill_valid;
  assign fill_done   = we && last;
  // Look one beat ahead on acceptance so a word is ready every cycle.
  assign rcnt        = sp_fire ? cnt + CNTW'(1) : cnt;
  assign raddr       = beat_addr(base, rcnt);
  assign waddr       = beat_addr(base, cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= XF_IDLE;
      cnt   <= '0;
      base  <= '0;
      vld   <= 1'b0;
    end else begin
      case (state)
        XF_IDLE: begin
          cnt <= '0;
          vld <= 1'b0;
          if (start_spill) begin
            state <= XF_SPILL;
            base  <= oldest;
          end else if (start_fill) begin
            state <= XF_FILL;
            base  <= WW'(oldest - WW'(HALF));
          end
        end
        XF_SPILL: begin
          vld <= 1'b1;
          if (sp_fire) begin
            cnt <= cnt + CNTW'(1);
            if (last) begin
              state <= XF_IDLE;
              vld   <= 1'b0;
            end
          end
        end
        XF_FILL: begin
          if (we) begin
            cnt <= cnt + CNTW'(1);
            if (last) state <= XF_IDLE;
          end
        end
        default: state <= XF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NWIN = 8,
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int WW   = $clog2(NWIN),
  localparam int RW   = $clog2(NREG),
  localparam int CW   = $clog2(NWIN + 1),
  localparam int AW   = WW + RW,
  localparam int HALF = NWIN / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          trap_enter_i,
  input  logic          trap_ack_i,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [RW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  output logic [WW-1:0] cwp_o,
  output logic [CW-1:0] resident_o,
  output logic          ovf_trap_o,
  output logic          unf_trap_o,
  output logic          busy_o,
  input  logic          spill_req_i,
  input  logic          fill_req_i,
  output logic          spill_valid_o,
  input  logic          spill_ready_i,
  output logic [DW-1:0] spill_data_o,
  input  logic          fill_valid_i,
  output logic          fill_ready_o,
  input  logic [DW-1:0] fill_data_i
);
  logic          busy, start, sp_done, fl_done, xf_we;
  logic [AW-1:0] xf_raddr, xf_waddr, raddr, waddr;
  logic [WW-1:0] oldest;
  logic          mem_we;
  logic [DW-1:0] wdata, q;

  regwin_ptr #(.NWIN(NWIN), .HALF(HALF)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .en        (!busy && !start),
    .call      (call_i || trap_enter_i),
    .ret       (ret_i),
    .ack       (trap_ack_i),
    .spill_done(sp_done),
    .fill_done (fl_done),
    .cwp       (cwp_o),
    .resident  (resident_o),
    .ovf       (ovf_trap_o),
    .unf       (unf_trap_o),
    .oldest    (oldest)
  );

  regwin_xfer #(.NWIN(NWIN), .NREG(NREG), .HALF(HALF)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .spill_req  (spill_req_i),
    .fill_req   (fill_req_i),
    .resident   (resident_o),
    .oldest     (oldest),
    .spill_ready(spill_ready_i),
    .fill_valid (fill_valid_i),
    .busy       (busy),
    .start      (start),
    .spill_valid(spill_valid_o),
    .fill_ready (fill_ready_o),
    .spill_done (sp_done),
    .fill_done  (fl_done),
    .raddr      (xf_raddr),
    .we         (xf_we),
    .waddr      (xf_waddr)
  );

  // The single storage port pair is shared between the core and the sequencer.
  assign mem_we = busy ? xf_we : wr_en_i;
  assign waddr  = busy ? xf_waddr : {cwp_o, wr_idx_i};
  assign wdata  = busy ? fill_data_i : wr_data_i;
  assign raddr  = busy ? xf_raddr : {cwp_o, rd_idx_i};

  regwin_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(waddr),
    .wdata(wdata),
    .raddr(raddr),
    .q    (q)
  );

  assign rd_data_o    = q;
  assign spill_data_o = q;
  assign busy_o       = busy;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int WW = $clog2(NWIN),
  localparam int CW = $clog2(NWIN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [WW-1:0] cwp_o,
  input logic [CW-1:0] resident_o,
  input logic          ovf_trap_o,
  input logic          unf_trap_o,
  input logic          trap_ack_i,
  input logic          busy_o,
  input logic          spill_valid_o,
  input logic          spill_ready_i,
  input logic [DW-1:0] spill_data_o
);
  AST_RES_RANGE: assert property (@(posedge clk) disable iff (rst)
    (resident_o >= CW'(1)) && (resident_o <= CW'(NWIN))); // R3

  AST_CWP_STEP: assert property (@(posedge clk) disable iff (rst)
    (cwp_o != $past(cwp_o)) |->
      ((WW'(cwp_o - $past(cwp_o)) == WW'(1)) ||
       (WW'($past(cwp_o) - cwp_o) == WW'(1)))); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_trap_o) |-> ($stable(cwp_o) && $stable(resident_o))); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    $rose(unf_trap_o) |-> ($stable(cwp_o) && $stable(resident_o))); // R5

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovf_trap_o && !trap_ack_i) |=> ovf_trap_o); // R6

  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (unf_trap_o && !trap_ack_i) |=> unf_trap_o); // R6

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(cwp_o)); // R11

  AST_SPILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (spill_valid_o && !spill_ready_i) |=>
      (spill_valid_o && $stable(spill_data_o))); // R9
endmodule

bind regwin_ctrl regwin_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cwp_o        (cwp_o),
  .resident_o   (resident_o),
  .ovf_trap_o   (ovf_trap_o),
  .unf_trap_o   (unf_trap_o),
  .trap_ack_i   (trap_ack_i),
  .busy_o       (busy_o),
  .spill_valid_o(spill_valid_o),
  .spill_ready_i(spill_ready_i),
  .spill_data_o (spill_data_o)
);

// File: tb/sim_regwin_ctrl.sv
`timescale 1ns/1ps
module sim_regwin_ctrl;
  localparam int NWIN = 8, NREG = 16, DW = 32, HALF = 4, BEATS = 64, GRP = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic call_i = 0, ret_i = 0, trap_enter_i = 0, trap_ack_i = 0, wr_en_i = 0;
  logic [3:0] wr_idx_i = 0, rd_idx_i = 0;
  logic [31:0] wr_data_i = 0, fill_data_i = 0;
  logic spill_req_i = 0, fill_req_i = 0, spill_ready_i = 0, fill_valid_i = 0;
  logic [31:0] rd_data_o, spill_data_o;
  logic [2:0] cwp_o;
  logic [3:0] resident_o;
  logic ovf_trap_o, unf_trap_o, busy_o, spill_valid_o, fill_ready_o;

  always #2 clk = ~clk;

  regwin_ctrl #(.NWIN(NWIN), .NREG(NREG), .DW(DW)) u0 (.*);

  // Bench model of every window and of the pointer state.
  logic [31:0] mm [NWIN][NREG];
  bit          mk [NWIN][NREG];
  logic [31:0] bk [GRP][BEATS];
  int bsp = 0, cw = 0, rs = 1;
  bit eo = 0, eu = 0;
  int nchk = 0, nfail = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic check_state();
    chk("R2", "cwp", 32'(cwp_o), 32'(cw));
    chk("R3", "resident", 32'(resident_o), 32'(rs));
    chk("R4", "ovf", 32'(ovf_trap_o), 32'(eo));
    chk("R5", "unf", 32'(unf_trap_o), 32'(eu));
  endtask

  task automatic idle_in();
    call_i = 0; ret_i = 0; trap_enter_i = 0; trap_ack_i = 0; wr_en_i = 0;
    spill_req_i = 0; fill_req_i = 0; spill_ready_i = 0; fill_valid_i = 0;
  endtask

  // One core cycle driven at a falling edge, checked at the next one.
  task automatic step(input bit c, input bit r, input bit t, input bit a,
                      input bit we, input int wi, input logic [31:0] wd,
                      input int ri);
    logic [31:0] erd;
    bit ek;
    call_i = c; ret_i = r; trap_enter_i = t; trap_ack_i = a;
    wr_en_i = we; wr_idx_i = 4'(wi); wr_data_i = wd; rd_idx_i = 4'(ri);
    ek = mk[cw][ri]; erd = mm[cw][ri];
    if (a) begin eo = 0; eu = 0; end
    if (we) begin mm[cw][wi] = wd; mk[cw][wi] = 1; end
    if (c || t) begin
      if (rs == NWIN) eo = 1; else begin cw = (cw + 1) % NWIN; rs++; end
    end else if (r) begin
      if (rs == 1) eu = 1; else begin cw = (cw + NWIN - 1) % NWIN; rs--; end
    end
    @(negedge clk);
    idle_in();
    check_state();
    chk("R11", "busy", 32'(busy_o), 32'd0);
    if (ek) chk("R7", "rd_data", rd_data_o, erd);
  endtask

  task automatic do_spill(input bit noise);
    int base, k, g;
    base = ((cw - rs + 1) % NWIN + NWIN) % NWIN;
    g = bsp % GRP;
    k = 0;
    spill_req_i = 1; call_i = noise; // R11: call in the start cycle is dropped
    @(negedge clk);
    idle_in();
    chk("R9", "busy at spill start", 32'(busy_o), 32'd1);
    while (busy_o) begin
      bit rdy;
      rdy = ($urandom % 4) != 0;
      spill_ready_i = rdy;
      if (noise) begin
        call_i = 1'($urandom); ret_i = 1'($urandom); trap_enter_i = 1'($urandom);
        wr_en_i = 1'($urandom); wr_idx_i = 4'($urandom); wr_data_i = $urandom;
      end
      if (spill_valid_o && rdy) begin
        int w;
        w = (base + k / NREG) % NWIN;
        if (mk[w][k % NREG]) chk("R9", "spill word", spill_data_o, mm[w][k % NREG]);
        if (k < BEATS) bk[g][k] = spill_data_o;
        k++;
      end
      @(negedge clk);
    end
    idle_in();
    bsp++;
    rs -= HALF;
    chk("R9", "spill beats", 32'(k), 32'(BEATS));
    check_state();
  endtask

  task automatic do_fill(input bit noise);
    int base, k, g;
    bit have;
    base = ((cw - rs + 1 - HALF) % NWIN + NWIN) % NWIN;
    have = bsp > 0;
    if (have) bsp--;
    g = bsp % GRP;
    k = 0;
    fill_req_i = 1; ret_i = noise; // R11: return in the start cycle is dropped
    @(negedge clk);
    idle_in();
    chk("R10", "busy at fill start", 32'(busy_o), 32'd1);
    while (busy_o) begin
      bit v;
      logic [31:0] d;
      v = ($urandom % 3) != 0;
      d = (have && k < BEATS) ? bk[g][k] : $urandom;
      fill_valid_i = v; fill_data_i = d;
      if (noise) begin
        call_i = 1'($urandom); ret_i = 1'($urandom);
        wr_en_i = 1'($urandom); wr_idx_i = 4'($urandom); wr_data_i = $urandom;
      end
      if (fill_ready_o && v) begin
        int w;
        w = (base + k / NREG) % NWIN;
        mm[w][k % NREG] = d; mk[w][k % NREG] = 1;
        k++;
      end
      @(negedge clk);
    end
    idle_in();
    rs += HALF;
    chk("R10", "fill beats", 32'(k), 32'(BEATS));
    check_state();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    foreach (mk[w, r]) mk[w][r] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "cwp", 32'(cwp_o), 0);
    chk("R1", "resident", 32'(resident_o), 1);
    chk("R1", "traps", {30'd0, ovf_trap_o, unf_trap_o}, 0);
    chk("R1", "busy", 32'(busy_o), 0);

    // R8: write racing a call lands in the old window
    step(1, 0, 0, 0, 1, 5, 32'hA5A5_0001, 0);
    step(0, 0, 0, 0, 1, 5, 32'h0000_BEEF, 0);
    step(0, 1, 0, 0, 0, 0, 0, 5);
    step(0, 0, 0, 0, 0, 0, 0, 5);
    chk("R8", "old window reg5", rd_data_o, 32'hA5A5_0001);
    // R7: read in the write cycle sees old data, next cycle sees new
    step(0, 0, 0, 0, 1, 5, 32'h1234_5678, 5);
    chk("R7", "read-first", rd_data_o, 32'hA5A5_0001);
    step(0, 0, 0, 0, 0, 0, 0, 5);
    chk("R7", "write visible", rd_data_o, 32'h1234_5678);

    // R5 then R6: underflow persists until acknowledge
    step(0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6", "unf held", 32'(unf_trap_o), 1);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    // R2: trap entry and call-over-return priority
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    while (rs < NWIN) step(1, 0, 0, 0, 1, $urandom % NREG, $urandom, 0);
    // R4 with R6: overflow set in the same cycle as an acknowledge stays set
    step(1, 0, 0, 1, 0, 0, 0, 0);
    chk("R6", "set beats ack", 32'(ovf_trap_o), 1);
    do_spill(1);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    // R10: fill ignored with more than 4 live windows
    fill_req_i = 1;
    @(negedge clk);
    idle_in();
    chk("R10", "fill ignored busy", 32'(busy_o), 0);
    chk("R10", "fill ignored resident", 32'(resident_o), 32'(rs));
    while (rs > 1) step(0, 1, 0, 0, 0, 0, 0, $urandom % NREG);
    // R9: spill ignored with 4 or fewer live windows
    spill_req_i = 1;
    @(negedge clk);
    idle_in();
    chk("R9", "spill ignored busy", 32'(busy_o), 0);
    chk("R9", "spill ignored resident", 32'(resident_o), 32'(rs));
    step(0, 1, 0, 0, 0, 0, 0, 0);
    do_fill(1);
    step(0, 0, 0, 1, 0, 0, 0, 0);

    // Constrained random traffic with trap servicing
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom % 100;
      step(op < 32, op >= 32 && op < 64, op >= 64 && op < 68, ($urandom % 8) == 0,
           1'($urandom), $urandom % NREG, $urandom, $urandom % NREG);
      if (eo) begin do_spill(0); step(0, 0, 0, 1, 0, 0, 0, 0); end
      if (eu) begin do_fill(0); step(0, 0, 0, 1, 0, 0, 0, 0); end
      if (($urandom % 60) == 0) begin
        if (rs > HALF) do_spill(1); else do_fill(1);
      end
    end
    finish_run();
  end
endmodule